// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block keeps subroutine return addresses for a small processor core. A call writes the address that follows the call into the stack. A return takes that address back out and hands it to the program counter. The stack has two entries of 12 bits each. Instruction decode sets the push and pop strobes. The top entry is always on the output, so the program counter can load it in the same cycle that the return is decoded.

There is no error reporting. A third push with no pop in between loses the oldest address. A pop on an empty stack gives back a copy of the bottom entry again.

Top module: `ras_stack`

## Requirements
- R1: While reset is low, both entries are cleared to zero. Directly after reset, `tos_o` reads 0.
- R2: `tos_o` always shows the level-1 (top) entry through combinational logic. During a cycle with `pop_i` high, it already holds the address being returned.
- R3: When `push_i` is high at a rising clock edge, the old level-1 value moves into level 2. `push_addr_i` is written into level 1.
- R4: When `pop_i` is high and `push_i` is low at a rising edge, level 1 takes the value of level 2. Level 2 keeps its value.
- R5: After three or more pushes in a row, the stack holds only the two most recent addresses. The newest is on top.
- R6: Pops beyond the number of stored addresses keep returning the value that level 2 held last.
- R7: When `push_i` and `pop_i` are both high, the push is carried out and the pop is ignored.
- R8: With neither strobe high, both entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Store a return address (from call decode) |
| push_addr_i | input | 12 | Return address to store |
| pop_i | input | 1 | Remove the top address (from return decode) |
| tos_o | output | 12 | Current top-of-stack address |

## Verification
The bench targets these corner cases:
- **Deep push run.** A design that keeps the oldest address instead of dropping it would return stale addresses after the pops that follow.
- **Pops past empty.** A design that shifts zero into the bottom, or clears level 2, would return 0 instead of repeating the bottom address.
- **Push and pop together.** If the pop wins, the top entry would come from level 2 and not from `push_addr_i`.
- **Top during a pop.** `tos_o` is compared during the pop cycle itself. A registered output would show up there one cycle late.

Random strobe patterns from a fixed seed then check every cycle against a bench model.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        RAS_HOLD = 2'd0,
        RAS_PUSH = 2'd1,
        RAS_POP  = 2'd2
    } ras_op_e;

    // Push has priority when both strobes arrive together.
    function automatic ras_op_e ras_decode(input logic push, input logic pop);
        if (push)
            return RAS_PUSH;
        else if (pop)
            return RAS_POP;
        else
            return RAS_HOLD;
    endfunction

endpackage

// File: rtl/ras_level.sv
module ras_level
    import ras_pkg::*;
#(
    parameter int W = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  ras_op_e       op_i,
    input  logic [W-1:0]  above_i,
    input  logic [W-1:0]  below_i,
    output logic [W-1:0]  q_o
);

    typedef struct packed {
        logic [W-1:0] val;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        unique case (op_i)
            RAS_PUSH: lvl_d.val = above_i;
            RAS_POP:  lvl_d.val = below_i;
            default:  lvl_d = lvl_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            lvl_q <= '0;
        else
            lvl_q <= lvl_d;
    end

    assign q_o = lvl_q.val;

endmodule

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] tos_o
);

    localparam int LAST = DEPTH - 1;

    ras_op_e op_d;
    logic [DEPTH-1:0][ADDR_W-1:0] stack_q;

    always_comb begin
        op_d = ras_decode(push_i, pop_i);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        logic [ADDR_W-1:0] above, below;

        if (i == 0) begin : g_top
            assign above = push_addr_i;
        end else begin : g_mid_above
            assign above = stack_q[i-1];
        end

        // The bottom level keeps itself on a pop, so extra pops repeat it.
        if (i == LAST) begin : g_bottom
            assign below = stack_q[i];
        end else begin : g_mid_below
            assign below = stack_q[i+1];
        end

        ras_level #(.W(ADDR_W)) u_level (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .op_i    (op_d),
            .above_i (above),
            .below_i (below),
            .q_o     (stack_q[i])
        );
    end

    assign tos_o = stack_q[0];

endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         push_i,
    input logic                         pop_i,
    input logic [ADDR_W-1:0]            push_addr_i,
    input logic [DEPTH-1:0][ADDR_W-1:0] stack_q
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk_i)
        !rst_ni |=> stack_q == '0);

    // R3, R7
    a_r3_push_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |=> stack_q[0] == $past(push_addr_i) && stack_q[1] == $past(stack_q[0]));

    // R4, R6
    a_r4_pop_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i && !push_i |=> stack_q[0] == $past(stack_q[1])
                             && stack_q[DEPTH-1] == $past(stack_q[DEPTH-1]));

    // R8
    a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !push_i && !pop_i |=> $stable(stack_q));

endmodule

bind ras_stack ras_stack_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .stack_q     (stack_q)
);

// File: tb/tb_ras_stack.sv
module tb_ras_stack;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [11:0] push_addr_i = '0;
    logic [11:0] tos_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] m_top = '0;
    logic [11:0] m_bot = '0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    ras_stack dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (push_i),
        .push_addr_i (push_addr_i),
        .pop_i       (pop_i),
        .tos_o       (tos_o)
    );

    function automatic logic [11:0] next_top(input logic ps, input logic pp,
                                             input logic [11:0] d,
                                             input logic [11:0] t, input logic [11:0] b);
        if (ps) return d;
        if (pp) return b;
        return t;
    endfunction

    function automatic logic [11:0] next_bot(input logic ps, input logic [11:0] t,
                                             input logic [11:0] b);
        return ps ? t : b;
    endfunction

    task automatic check(input string req, input logic [11:0] exp);
        n_cmp++;
        if (tos_o !== exp) begin
            n_bad++;
            $display("FAIL %s: tos_o=%h expected=%h", req, tos_o, exp);
        end
    endtask

    // Drive at the falling edge, check the top in the same cycle,
    // clock it in, then check the top after the edge.
    task automatic step(input logic ps, input logic pp, input logic [11:0] d,
                        input string req);
        logic [11:0] t, b;
        push_i = ps;
        pop_i = pp;
        push_addr_i = d;
        #1;
        check("R2", m_top);
        t = next_top(ps, pp, d, m_top, m_bot);
        b = next_bot(ps, m_top, m_bot);
        @(posedge clk_i);
        m_top = t;
        m_bot = b;
        @(negedge clk_i);
        push_i = 1'b0;
        pop_i = 1'b0;
        check(req, m_top);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'd1234);
        repeat (3) @(negedge clk_i);
        check("R1", 12'h000);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", 12'h000);

        // R3, R5: three pushes in a row keep the two newest.
        step(1, 0, 12'h111, "R3");
        step(1, 0, 12'h222, "R3");
        step(1, 0, 12'h333, "R5");
        step(0, 0, 12'hfff, "R8");
        step(0, 1, 12'h000, "R4");
        // R5: the oldest (111) is gone; R6: extra pops repeat 222.
        step(0, 1, 12'h000, "R6");
        step(0, 1, 12'h000, "R6");
        step(0, 1, 12'h000, "R6");

        // R7: push and pop together, push wins.
        step(1, 0, 12'h0a5, "R3");
        step(1, 1, 12'h5a0, "R7");
        step(0, 1, 12'h000, "R7");
        step(0, 1, 12'h000, "R6");

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            r = $urandom;
            step(r[0] & r[1], r[2], r[15:4], "R8");
        end

        // Reset in the middle of use clears both levels (R1).
        step(1, 0, 12'h777, "R3");
        rst_ni = 1'b0;
        #1;
        m_top = '0;
        m_bot = '0;
        check("R1", 12'h000);
        @(negedge clk_i);
        rst_ni = 1'b1;
        step(0, 1, 12'h000, "R1");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule